// File: doc/BRIEF.md
# Quadrature Direct Digital Synthesis Oscillator

This block produces a cosine and a sine sample stream from a fixed-point phase accumulator. On every clock in which the sample strobe is high, the unsigned tuning word is added to the accumulator, and the previous phase value is turned into a lookup address. The address is formed by rounding the phase to its top address bits, not by truncating it. A pseudo-random dither can first be added below the address LSB. This breaks up the periodic phase error that otherwise shows up as spurs in the spectrum.

The output frequency is `fs * N / 2^ACC_W`, so one step of the tuning word moves the frequency by `fs / 2^ACC_W`. A wanted frequency `f0` with `0 < f0 < fs/2` is reached with `N = round(f0 * 2^ACC_W / fs)`. The sine and cosine values are computed when the design is elaborated and stored as one quarter-wave magnitude table. Both outputs read that table through quadrant folding. The defaults are a 32-bit accumulator, a 12-bit address and 14-bit signed samples.

Top module: `dds_quad_osc`

## Requirements
- R1: While reset is high, the accumulator output, both samples and the valid flag are zero.
- R2: Each clock with the strobe high adds the tuning word to the accumulator, and the new sum shows on `acc_o` after that edge. A clock with the strobe low leaves the accumulator unchanged.
- R3: The accumulator wraps modulo 2^ACC_W. For example, 0 plus 0xFFFFFFFF gives 0xFFFFFFFF, and adding 0xFFFFFFFF again gives 0xFFFFFFFE.
- R4: With dither off, the address for a strobe is `floor((P + 2^(S-1)) / 2^S) mod 2^ADDR_W`, where `S = ACC_W - ADDR_W` and P is the accumulator value before that strobe's addition. Rounding up past the last entry gives address 0.
- R5: For address a, `sin_o = round(M * sin(2*pi*a / 2^ADDR_W))` and `cos_o = round(M * cos(2*pi*a / 2^ADDR_W))`. Here `M = 2^(AMP_W-1) - 1`, rounding is half away from zero, and the values are two's complement.
- R6: `valid_o` is high exactly on the second rising edge after the edge that accepts a strobe, and is low otherwise. The samples update only together with a valid result and hold their value at all other times.
- R7: With dither on, a signed pseudo-random offset is added to P before rounding. Its magnitude is at most 2^(S-3). The resulting address is therefore the undithered address or one of its two neighbours, modulo 2^ADDR_W.
- R8: With dither on and phases that sit on a rounding boundary (P an odd multiple of 2^(S-1)), some samples take the lower neighbouring address instead of the rounded-up one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sample_en_i | input | 1 | Sample strobe: advance the phase and start one output sample |
| tune_i | input | ACC_W | Unsigned phase increment (tuning word) |
| dither_en_i | input | 1 | Add pseudo-random dither before address rounding |
| cos_o | output | AMP_W | Signed cosine sample |
| sin_o | output | AMP_W | Signed sine sample |
| acc_o | output | ACC_W | Raw phase accumulator value |
| valid_o | output | 1 | Samples updated this cycle |

## Verification
The bench walks the phase to the exact quarter-circle points, where a wrong quadrant fold would swap the sign or return the neighbouring table entry. It also puts phases exactly on the half-LSB rounding boundary and just below it, which separates rounding from truncation. A phase one count below full circle must fold back to address 0, and a design that kept the carry would index past the table. Tuning words near 2^ACC_W check the accumulator wrap, and idle gaps between strobes catch an output that moves without a valid result or a valid flag with the wrong latency. With dither on, each sample must match the table at the rounded address or at one of its neighbours, and at least one boundary phase must fall to the lower neighbour. A dither that is too large, or missing altogether, fails one of these two checks.

// File: rtl/dds_osc_pkg.sv
package dds_osc_pkg;

    // Dither source: 24-bit Galois LFSR, x^24 + x^23 + x^22 + x^17 + 1
    localparam int                LFSR_W    = 24;
    localparam logic [LFSR_W-1:0] LFSR_MASK = 24'hE1_0000;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 24'h5A_C3_91;

    // Quadrant of the phase circle, taken from the two address MSBs
    typedef enum logic [1:0] {
        QD_I   = 2'd0,
        QD_II  = 2'd1,
        QD_III = 2'd2,
        QD_IV  = 2'd3
    } quad_e;

    // Dither word width: two bits under half an address LSB, clamped to the LFSR width
    function automatic int dither_width(input int acc_w, input int addr_w);
        int w;
        w = acc_w - addr_w - 2;
        if (w < 1)
            w = 1;
        if (w > LFSR_W)
            w = LFSR_W;
        return w;
    endfunction

    function automatic logic [LFSR_W-1:0] lfsr_advance(input logic [LFSR_W-1:0] s);
        return (s >> 1) ^ (s[0] ? LFSR_MASK : '0);
    endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             step_en_i,
    input  logic [ACC_W-1:0] tune_i,
    output logic [ACC_W-1:0] acc_q
);

    always_ff @(posedge clk_i) begin
        if (rst_i)
            acc_q <= '0;
        else if (step_en_i)
            acc_q <= acc_q + tune_i;
    end

    // R2
    acc_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        step_en_i |=> (acc_q == $past(acc_q) + $past(tune_i)));

    // R2
    acc_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !step_en_i |=> $stable(acc_q));

endmodule

// File: rtl/dds_dither_src.sv
module dds_dither_src
    import dds_osc_pkg::*;
#(
    parameter int ACC_W  = 32,
    parameter int DITH_W = 18
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    output logic [ACC_W-1:0] dith_o
);

    logic [LFSR_W-1:0] lfsr_q;
    logic [DITH_W-1:0] raw;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            lfsr_q <= LFSR_SEED;
        else
            lfsr_q <= lfsr_advance(lfsr_q);
    end

    assign raw = lfsr_q[DITH_W-1:0];

    generate
        if (DITH_W < ACC_W) begin : g_ext
            assign dith_o = en_i ? {{(ACC_W-DITH_W){raw[DITH_W-1]}}, raw} : '0;
        end else begin : g_full
            assign dith_o = en_i ? raw[ACC_W-1:0] : '0;
        end
    endgenerate

    // R7
    lfsr_live_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        lfsr_q != '0);

endmodule

// File: rtl/dds_phase_quant.sv
module dds_phase_quant #(
    parameter int ACC_W  = 32,
    parameter int ADDR_W = 12
) (
    input  logic [ACC_W-1:0]  phase_i,
    input  logic [ACC_W-1:0]  dith_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int               SHIFT = ACC_W - ADDR_W;
    localparam logic [ACC_W-1:0] HALF  = ACC_W'(1) << (SHIFT - 1);

    logic [ACC_W-1:0] biased;

    // Modular sum: a carry out of the top drops, so rounding past the end lands on 0
    assign biased = phase_i + dith_i + HALF;
    assign addr_o = biased[ACC_W-1 -: ADDR_W];

endmodule

// File: rtl/dds_sincos_rom.sv
module dds_sincos_rom
    import dds_osc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int AMP_W  = 14
) (
    input  logic [ADDR_W-1:0]       addr_i,
    output logic signed [AMP_W-1:0] cos_o,
    output logic signed [AMP_W-1:0] sin_o
);

    localparam int  CIRCLE = 1 << ADDR_W;
    localparam int  QUART  = CIRCLE / 4;
    localparam int  PEAK   = (1 << (AMP_W - 1)) - 1;
    localparam real TWO_PI = 6.283185307179586;

    // Quarter-wave magnitudes, entries 0..QUART inclusive
    logic [AMP_W-2:0] mag_tbl [0:QUART];

    for (genvar i = 0; i <= QUART; i++) begin : g_tbl
        localparam real ANG = TWO_PI * real'(i) / real'(CIRCLE);
        localparam int  VAL = $rtoi(real'(PEAK) * $sin(ANG) + 0.5);
        assign mag_tbl[i] = VAL[AMP_W-2:0];
    end

    logic signed [AMP_W-1:0] port_val [2];

    // Port 0 reads cosine as sine a quarter turn ahead, port 1 reads sine
    for (genvar p = 0; p < 2; p++) begin : g_port
        logic [ADDR_W-1:0] pa;
        quad_e             qd;
        logic [ADDR_W-3:0] frac;
        logic [ADDR_W-2:0] idx;
        logic [AMP_W-2:0]  mag;

        assign pa   = addr_i + ((p == 0) ? ADDR_W'(QUART) : '0);
        assign qd   = quad_e'(pa[ADDR_W-1 -: 2]);
        assign frac = pa[ADDR_W-3:0];

        always_comb begin
            if (qd == QD_II || qd == QD_IV)
                idx = (ADDR_W-1)'(QUART) - {1'b0, frac};
            else
                idx = {1'b0, frac};
        end

        assign mag = mag_tbl[idx];

        always_comb begin
            if (qd == QD_III || qd == QD_IV)
                port_val[p] = -$signed({1'b0, mag});
            else
                port_val[p] = $signed({1'b0, mag});
        end
    end

    assign cos_o = port_val[0];
    assign sin_o = port_val[1];

endmodule

// File: rtl/dds_quad_osc.sv
module dds_quad_osc
    import dds_osc_pkg::*;
#(
    parameter int ACC_W  = 32,
    parameter int ADDR_W = 12,
    parameter int AMP_W  = 14
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    sample_en_i,
    input  logic [ACC_W-1:0]        tune_i,
    input  logic                    dither_en_i,
    output logic signed [AMP_W-1:0] cos_o,
    output logic signed [AMP_W-1:0] sin_o,
    output logic [ACC_W-1:0]        acc_o,
    output logic                    valid_o
);

    localparam int DITH_W = dither_width(ACC_W, ADDR_W);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
    } addr_stage_t;

    typedef struct packed {
        logic                    vld;
        logic signed [AMP_W-1:0] cos;
        logic signed [AMP_W-1:0] sin;
    } out_stage_t;

    logic [ACC_W-1:0]        acc_q;
    logic [ACC_W-1:0]        dith;
    logic [ADDR_W-1:0]       addr_now;
    logic signed [AMP_W-1:0] rom_cos;
    logic signed [AMP_W-1:0] rom_sin;
    addr_stage_t             s1_q;
    out_stage_t              s2_q;

    dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .step_en_i (sample_en_i),
        .tune_i    (tune_i),
        .acc_q     (acc_q)
    );

    dds_dither_src #(.ACC_W(ACC_W), .DITH_W(DITH_W)) u_dith (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (dither_en_i),
        .dith_o (dith)
    );

    dds_phase_quant #(.ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_quant (
        .phase_i (acc_q),
        .dith_i  (dith),
        .addr_o  (addr_now)
    );

    // Stage 1: capture the rounded address of the phase before this step
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s1_q <= '0;
        end else begin
            s1_q.vld <= sample_en_i;
            if (sample_en_i)
                s1_q.addr <= addr_now;
        end
    end

    dds_sincos_rom #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_rom (
        .addr_i (s1_q.addr),
        .cos_o  (rom_cos),
        .sin_o  (rom_sin)
    );

    // Stage 2: register the table outputs
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s2_q <= '0;
        end else begin
            s2_q.vld <= s1_q.vld;
            if (s1_q.vld) begin
                s2_q.cos <= rom_cos;
                s2_q.sin <= rom_sin;
            end
        end
    end

    assign cos_o   = s2_q.cos;
    assign sin_o   = s2_q.sin;
    assign valid_o = s2_q.vld;
    assign acc_o   = acc_q;

    // R6
    valid_lat_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        sample_en_i |-> ##2 valid_o);

    // R6
    valid_gap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !sample_en_i |-> ##2 !valid_o);

    // R6
    out_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !s1_q.vld |=> ($stable(cos_o) && $stable(sin_o)));

endmodule

// File: tb/dds_quad_osc_bench.sv
module dds_quad_osc_bench;

    localparam int ACC_W  = 32;
    localparam int ADDR_W = 12;
    localparam int AMP_W  = 14;
    localparam int CIRCLE = 1 << ADDR_W;
    localparam real PEAK  = 8191.0;
    localparam real TWO_PI = 6.283185307179586;

    logic                    clk = 1'b0;
    logic                    rst;
    logic                    sample_en;
    logic [ACC_W-1:0]        tune;
    logic                    dither_en;
    logic signed [AMP_W-1:0] cos_o;
    logic signed [AMP_W-1:0] sin_o;
    logic [ACC_W-1:0]        acc_o;
    logic                    valid_o;

    always #10 clk = ~clk;

    dds_quad_osc u_dds_quad_osc (
        .clk_i       (clk),
        .rst_i       (rst),
        .sample_en_i (sample_en),
        .tune_i      (tune),
        .dither_en_i (dither_en),
        .cos_o       (cos_o),
        .sin_o       (sin_o),
        .acc_o       (acc_o),
        .valid_o     (valid_o)
    );

    typedef struct {
        int    addr;
        bit    dith;
        string req;
    } item_t;

    item_t       sb_q[$];
    int          n_checks = 0;
    int          n_errors = 0;
    int          dith_moved = 0;
    bit          finished = 0;
    logic [31:0] model_acc = '0;
    logic [1:0]  hist = '0;
    int          last_cos = 0;
    int          last_sin = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int rnd(input real v);
        if (v >= 0.0)
            return $rtoi(v + 0.5);
        return -$rtoi(-v + 0.5);
    endfunction

    function automatic int exp_sin(input int a);
        return rnd(PEAK * $sin(TWO_PI * real'(a) / real'(CIRCLE)));
    endfunction

    function automatic int exp_cos(input int a);
        return rnd(PEAK * $cos(TWO_PI * real'(a) / real'(CIRCLE)));
    endfunction

    function automatic int addr_of(input logic [31:0] ph);
        logic [31:0] b;
        b = ph + 32'h0008_0000;
        return int'(b[31:20]);
    endfunction

    // Strobe once; caller is at a falling edge
    task automatic step(input logic [31:0] n, input bit dith, input string req);
        item_t it;
        sample_en = 1'b1;
        tune      = n;
        dither_en = dith;
        it.addr = addr_of(model_acc);
        it.dith = dith;
        it.req  = req;
        sb_q.push_back(it);
        model_acc = model_acc + n;
        @(negedge clk);
        sample_en = 1'b0;
        chk(acc_o == model_acc, (req == "R3") ? "R3" : "R2", "acc_o",
            longint'(acc_o), longint'(model_acc));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            sample_en = 1'b0;
            tune      = 32'hDEAD_BEEF;
            @(negedge clk);
            chk(acc_o == model_acc, "R2", "acc_o idle", longint'(acc_o), longint'(model_acc));
        end
    endtask

    task automatic do_reset();
        rst       = 1'b1;
        sample_en = 1'b0;
        tune      = '0;
        dither_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(acc_o == '0, "R1", "acc_o in reset", longint'(acc_o), 0);
        chk(valid_o == 1'b0, "R1", "valid_o in reset", longint'(valid_o), 0);
        chk(cos_o == '0, "R1", "cos_o in reset", longint'(cos_o), 0);
        chk(sin_o == '0, "R1", "sin_o in reset", longint'(sin_o), 0);
        model_acc = '0;
        last_cos  = 0;
        last_sin  = 0;
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    always @(posedge clk) begin
        if (rst)
            hist <= '0;
        else
            hist <= {hist[0], sample_en};
    end

    // Monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (valid_o != hist[1])
                chk(1'b0, "R6", "valid_o timing", longint'(valid_o), longint'(hist[1]));
            if (valid_o) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R6", "unexpected valid", 1, 0);
                end else begin
                    item_t it;
                    int    c, s;
                    it = sb_q.pop_front();
                    c  = int'(cos_o);
                    s  = int'(sin_o);
                    if (!it.dith) begin
                        chk(c == exp_cos(it.addr), it.req, "cos_o", c, exp_cos(it.addr));
                        chk(s == exp_sin(it.addr), it.req, "sin_o", s, exp_sin(it.addr));
                    end else begin
                        bit hit;
                        hit = 0;
                        for (int d = -1; d <= 1; d++) begin
                            int a;
                            a = (it.addr + d + CIRCLE) % CIRCLE;
                            if (c == exp_cos(a) && s == exp_sin(a))
                                hit = 1;
                        end
                        chk(hit, "R7", "dithered sin_o within one address", s, exp_sin(it.addr));
                        if (c != exp_cos(it.addr) || s != exp_sin(it.addr))
                            dith_moved++;
                    end
                end
            end else begin
                chk(int'(cos_o) == last_cos && int'(sin_o) == last_sin, "R6",
                    "sin_o held without valid", longint'(sin_o), last_sin);
            end
            last_cos = int'(cos_o);
            last_sin = int'(sin_o);
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] lcg;
        rst = 1'b1;
        sample_en = 1'b0;
        tune = '0;
        dither_en = 1'b0;
        @(negedge clk);
        do_reset();

        // R5: zero phase gives cos at peak, sin at zero
        for (int i = 0; i < 3; i++) step(32'd0, 0, "R5");
        idle(3);

        // R5: quarter-turn steps hit each quadrant boundary
        for (int i = 0; i < 8; i++) step(32'h4000_0000, 0, "R5");
        idle(4);

        // R2: 1 kHz at 48 kHz sample rate, with idle gaps
        for (int i = 0; i < 100; i++) begin
            step(32'd89478485, 0, "R5");
            if (i % 10 == 9) idle(2);
        end
        idle(3);

        // R3: wrap with large tuning words
        for (int i = 0; i < 4; i++) step(32'hFFFF_FFFF, 0, "R3");
        for (int i = 0; i < 4; i++) step(32'h8000_0001, 0, "R3");
        idle(3);

        // R4: restart from zero; rounding boundary and wrap to address 0
        do_reset();
        for (int i = 0; i < 4; i++) step(32'h0007_FFFF, 0, "R4");
        for (int i = 0; i < 6; i++) step(32'h0008_0000, 0, "R4");
        idle(3);
        do_reset();
        step(32'hFFFF_FFFF, 0, "R4");
        step(32'h0000_0000, 0, "R4");
        step(32'h0000_0000, 0, "R4");
        idle(3);

        // R7 / R8: dither on at half-LSB boundaries
        do_reset();
        for (int i = 0; i < 64; i++) step(32'h0008_0000, 1, "R7");
        idle(3);
        chk(dith_moved > 0, "R8", "dithered samples that moved", dith_moved, 1);

        // R7: dither off again gives exact values
        for (int i = 0; i < 16; i++) step(32'h0008_0000, 0, "R7");
        idle(3);

        // R5: pseudo-random tuning words, back to back
        lcg = 32'h1234_5678;
        for (int i = 0; i < 60; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            step(lcg, 0, "R5");
        end
        idle(4);
        chk(sb_q.size() == 0, "R6", "results outstanding", sb_q.size(), 0);

        if (!finished) begin
            finished = 1;
            summary();
            $finish;
        end
    end

endmodule